// File: doc/BRIEF.md
# NAND Sector Hamming ECC Corrector

This block checks one flash page against its stored error-correcting code and locates single-bit errors. Each 512-byte sector is protected by a 24-bit Hamming code. The code holds twelve pairs of parities, one even and one odd for each power-of-two span from 1 to 2048. The caller presents the code read back from the spare area and the code the hardware generator computed while the data streamed in. The block forms the 24-bit syndrome, classifies the sector as clean, corrected or uncorrectable, and for a correctable error reports the byte offset and bit index of the bad bit. It also issues a one-cycle XOR-write strobe, with a page byte address and a bit mask, that a sector buffer can apply to repair the bit.

A request covers either sector 0 alone or a full page of four sectors. The sectors are handled one per clock. Processing stops at the first sector that cannot be corrected. An erased sector, whose stored code is all ones and whose computed code is all zeros, is reported as clean rather than as a failure.

Top module: `nand_ecc_corrector`

## Requirements
- R1: While reset is held low, every output reads zero. Reset is synchronous and active low.
- R2: Raw code layout, per sector. Bits [7:0] hold the even parities for spans 1 to 128, with bit i covering span 2^i. Bits [15:8] hold the odd parities for the same spans. Bits [19:16] hold the even parities for spans 256 to 2048, and bits [23:20] hold the odd ones. Each even parity of the stored code is compared only with the even parity of the same span in the computed code, and each odd parity likewise.
- R3: A sector whose stored and computed raw codes are equal reports status 2'b00 (clean), with fix_byte, fix_bit, fix_addr and fix_mask all zero.
- R4: When exactly 12 syndrome bits are set, the status is 2'b01 (corrected). fix_byte is formed from the odd-parity syndrome bits of spans 8 to 2048, with span 8 as its LSB. fix_bit is formed from the odd-parity syndrome bits of spans 1, 2 and 4, with span 1 as its LSB.
- R5: fix_we pulses together with every corrected status and only then. While it is high, fix_addr = sector*512 + fix_byte and fix_mask = 1 << fix_bit. When no status is valid, fix_we is low.
- R6: Any other nonzero syndrome, including a weight of 1 or 11, reports status 2'b10 (uncorrectable). Status 2'b11 never occurs.
- R7: A stored code of 24'hFFFFFF paired with a computed code of zero reports clean.
- R8: If start is sampled high at rising edge N while busy is low, busy reads high after edge N. The status of the first sector is valid, with stat_valid high, in the cycle after edge N+1.
- R9: With page_mode=1, sectors 0 to 3 are checked in order, one status per cycle. Sector i uses bits [24i+23:24i] of both code inputs and reports stat_sector=i. stat_last marks the final status of the request.
- R10: An uncorrectable sector ends the request. It carries stat_last, no later sector is reported, and busy is low in the cycle that shows it.
- R11: start is ignored while busy is high. A new request is accepted in any cycle where busy is low, including the cycle that shows the previous request's final status.
- R12: With page_mode=0, only sector 0 (bits [23:0]) is checked, and one status with stat_last is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when busy is low |
| page_mode | input | 1 | 1 = four-sector page, 0 = sector 0 only |
| stored_code | input | 96 | Codes read from the spare area, 24 bits per sector |
| calc_code | input | 96 | Codes from the hardware generator, 24 bits per sector |
| busy | output | 1 | Request in progress; code inputs must hold |
| stat_valid | output | 1 | Status fields valid this cycle |
| stat_code | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| stat_sector | output | 2 | Sector the status belongs to |
| stat_last | output | 1 | Final status of the request |
| fix_byte | output | 9 | Byte offset within the sector |
| fix_bit | output | 3 | Bit index within the byte |
| fix_we | output | 1 | Buffer repair strobe |
| fix_addr | output | 11 | Page byte address to repair |
| fix_mask | output | 8 | XOR mask for the repaired byte |

## Verification
The bench builds the block with its default parameters: 512-byte sectors and four sectors per page. With these values all twelve parity pairs and the full 9-bit byte offset are in play, so errors at byte 0 bit 0 and at byte 511 bit 7 both occur. The four-sector page makes the sector address offset visible, and it shows early termination after sector 1 as well as a back-to-back request in the final-status cycle. Random stored and computed codes are also applied. These reach weights of 1, 11 and 12, the erased pairing, and a request refused while the block is busy.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
// Shared types for the sector ECC corrector.
package nand_ecc_pkg;

    // Per-sector verdict; the encoding is visible on stat_code.
    typedef enum logic [1:0] {
        SEC_CLEAN = 2'b00,
        SEC_FIXED = 2'b01,
        SEC_FAIL  = 2'b10
    } sec_status_e;

endpackage

// File: rtl/nand_ecc_repack.sv
`timescale 1ns/1ps
// Splits a raw sector code into even and odd parity vectors indexed by span.
// Assumes PAIRS >= 9: the low eight spans sit in two whole bytes, and the
// remaining spans share the third field, even half below odd half.
module nand_ecc_repack #(
    parameter int PAIRS = 12
) (
    input  logic [2*PAIRS-1:0] raw,
    output logic [PAIRS-1:0]   even_par,
    output logic [PAIRS-1:0]   odd_par
);
    localparam int LO = 8;
    localparam int HI = PAIRS - LO;

    genvar k;
    generate
        for (k = 0; k < PAIRS; k++) begin : g_span
            if (k < LO) begin : g_low
                // low spans: even byte then odd byte
                assign even_par[k] = raw[k];
                assign odd_par[k]  = raw[LO + k];
            end else begin : g_high
                // high spans: shared field, even nibble below odd nibble
                assign even_par[k] = raw[2*LO + (k - LO)];
                assign odd_par[k]  = raw[2*LO + HI + (k - LO)];
            end
        end
    endgenerate
endmodule

// File: rtl/nand_ecc_syndrome.sv
`timescale 1ns/1ps
// First pipeline stage: repacks both codes, forms the syndrome and its
// weight, and flags the equal and erased cases. Everything is registered
// when load is high; otherwise the stage empties.
module nand_ecc_syndrome #(
    parameter int PAIRS = 12,
    parameter int SEC_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [SEC_W-1:0]          load_idx,
    input  logic                      load_last,
    input  logic [2*PAIRS-1:0]        stored_raw,
    input  logic [2*PAIRS-1:0]        calc_raw,
    output logic                      s1_valid,
    output logic [SEC_W-1:0]          s1_idx,
    output logic                      s1_last,
    output logic [PAIRS-1:0]          s1_syn_odd,
    output logic [$clog2(2*PAIRS+1)-1:0] s1_pop,
    output logic                      s1_erased,
    output logic                      s1_same
);
    localparam int CODE_W = 2 * PAIRS;
    localparam int POP_W  = $clog2(CODE_W + 1);

    logic [PAIRS-1:0]  st_even, st_odd, ca_even, ca_odd;
    logic [PAIRS-1:0]  syn_even, syn_odd;
    logic [CODE_W-1:0] syn_all;
    logic [POP_W-1:0]  pop_c;
    logic              erased_c, same_c;

    nand_ecc_repack #(.PAIRS(PAIRS)) u_rp_stored (
        .raw      (stored_raw),
        .even_par (st_even),
        .odd_par  (st_odd)
    );

    nand_ecc_repack #(.PAIRS(PAIRS)) u_rp_calc (
        .raw      (calc_raw),
        .even_par (ca_even),
        .odd_par  (ca_odd)
    );

    // Syndrome halves: even against even, odd against odd
    assign syn_even = st_even ^ ca_even;
    assign syn_odd  = st_odd  ^ ca_odd;
    assign syn_all  = {syn_odd, syn_even};

    // Syndrome weight
    always_comb begin
        pop_c = '0;
        for (int i = 0; i < CODE_W; i++) begin
            pop_c = pop_c + POP_W'(syn_all[i]);
        end
    end

    // Erased sector: stored all ones, computed all zeros
    assign erased_c = (&stored_raw) && (ca_even == '0) && (ca_odd == '0);
    assign same_c   = (stored_raw == calc_raw);

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_idx     <= '0;
            s1_last    <= 1'b0;
            s1_syn_odd <= '0;
            s1_pop     <= '0;
            s1_erased  <= 1'b0;
            s1_same    <= 1'b0;
        end else begin
            s1_valid <= load;
            if (load) begin
                s1_idx     <= load_idx;
                s1_last    <= load_last;
                s1_syn_odd <= syn_odd;
                s1_pop     <= pop_c;
                s1_erased  <= erased_c;
                s1_same    <= same_c;
            end
        end
    end
endmodule

// File: rtl/nand_ecc_classify.sv
`timescale 1ns/1ps
// Second pipeline stage: classifies the registered syndrome and registers the
// status and the repair strobe. fail_now exposes the verdict one cycle early
// so that the sequencer can stop issuing sectors.
module nand_ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int PAIRS  = 12,
    parameter int SEC_W  = 2,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s1_valid,
    input  logic [SEC_W-1:0]          s1_idx,
    input  logic                      s1_last,
    input  logic [PAIRS-1:0]          s1_syn_odd,
    input  logic [$clog2(2*PAIRS+1)-1:0] s1_pop,
    input  logic                      s1_erased,
    input  logic                      s1_same,
    output logic                      fail_now,
    output logic                      stat_valid,
    output logic [1:0]                stat_code,
    output logic [SEC_W-1:0]          stat_sector,
    output logic                      stat_last,
    output logic [BYTE_W-1:0]         fix_byte,
    output logic [2:0]                fix_bit,
    output logic                      fix_we,
    output logic [ADDR_W-1:0]         fix_addr,
    output logic [7:0]                fix_mask
);
    localparam int POP_W = $clog2(2*PAIRS + 1);

    sec_status_e        cls;
    logic [BYTE_W-1:0]  loc_byte;
    logic [2:0]         loc_bit;

    // Verdict: equal codes, then one flipped data bit, then erased page
    always_comb begin
        if (s1_same)                          cls = SEC_CLEAN;
        else if (s1_pop == POP_W'(PAIRS))     cls = SEC_FIXED;
        else if (s1_erased)                   cls = SEC_CLEAN;
        else                                  cls = SEC_FAIL;
    end

    // Error location from the odd-parity syndrome bits
    assign loc_bit  = s1_syn_odd[2:0];
    assign loc_byte = s1_syn_odd[PAIRS-1:3];
    assign fail_now = s1_valid && (cls == SEC_FAIL);

    // Status and repair register
    always_ff @(posedge clk) begin
        if (!rst_n || !s1_valid) begin
            stat_valid  <= 1'b0;
            stat_code   <= SEC_CLEAN;
            stat_sector <= '0;
            stat_last   <= 1'b0;
            fix_byte    <= '0;
            fix_bit     <= '0;
            fix_we      <= 1'b0;
            fix_addr    <= '0;
            fix_mask    <= '0;
        end else begin
            stat_valid  <= 1'b1;
            stat_code   <= cls;
            stat_sector <= s1_idx;
            stat_last   <= s1_last || (cls == SEC_FAIL);
            if (cls == SEC_FIXED) begin
                fix_byte <= loc_byte;
                fix_bit  <= loc_bit;
                fix_we   <= 1'b1;
                fix_addr <= {s1_idx, loc_byte};
                fix_mask <= 8'd1 << loc_bit;
            end else begin
                fix_byte <= '0;
                fix_bit  <= '0;
                fix_we   <= 1'b0;
                fix_addr <= '0;
                fix_mask <= '0;
            end
        end
    end
endmodule

// File: rtl/nand_ecc_corrector.sv
`timescale 1ns/1ps
// Page-level Hamming ECC corrector. Accepts a request when idle, feeds one
// sector per clock into the two-stage syndrome/classify pipeline and stops
// after the last sector or the first uncorrectable one.
// Assumes the code inputs hold steady while busy is high and that
// SECTOR_BYTES is a power of two of at least 64.
module nand_ecc_corrector #(
    parameter int SECTOR_BYTES = 512,
    parameter int SECTORS      = 4,
    localparam int BYTE_W = $clog2(SECTOR_BYTES),
    localparam int PAIRS  = BYTE_W + 3,
    localparam int CODE_W = 2 * PAIRS,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int ADDR_W = BYTE_W + SEC_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        page_mode,
    input  logic [SECTORS*CODE_W-1:0]   stored_code,
    input  logic [SECTORS*CODE_W-1:0]   calc_code,
    output logic                        busy,
    output logic                        stat_valid,
    output logic [1:0]                  stat_code,
    output logic [SEC_W-1:0]            stat_sector,
    output logic                        stat_last,
    output logic [BYTE_W-1:0]           fix_byte,
    output logic [2:0]                  fix_bit,
    output logic                        fix_we,
    output logic [ADDR_W-1:0]           fix_addr,
    output logic [7:0]                  fix_mask
);
    localparam int POP_W = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] st_sec [SECTORS];
    logic [CODE_W-1:0] ca_sec [SECTORS];

    logic              busy_q;
    logic [SEC_W-1:0]  req_last_q;
    logic              accept, advance, load, load_last;
    logic [SEC_W-1:0]  load_idx, last_sel;

    logic              s1_valid, s1_last, s1_erased, s1_same, fail_now;
    logic [SEC_W-1:0]  s1_idx;
    logic [PAIRS-1:0]  s1_syn_odd;
    logic [POP_W-1:0]  s1_pop;

    // Per-sector slices of the flat code inputs
    genvar s;
    generate
        for (s = 0; s < SECTORS; s++) begin : g_slice
            assign st_sec[s] = stored_code[s*CODE_W +: CODE_W];
            assign ca_sec[s] = calc_code[s*CODE_W +: CODE_W];
        end
    endgenerate

    // Issue control: a fresh request or the next sector of the current one
    assign accept   = start && !busy_q;
    assign advance  = s1_valid && !s1_last && !fail_now;
    assign load     = accept || advance;
    assign load_idx = accept ? '0 : s1_idx + SEC_W'(1);
    assign last_sel = accept ? (page_mode ? SEC_W'(SECTORS - 1) : '0) : req_last_q;
    assign load_last = (load_idx == last_sel);

    // Request state: busy until the final status is registered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            req_last_q <= '0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            req_last_q <= last_sel;
        end else if (s1_valid && (s1_last || fail_now)) begin
            busy_q     <= 1'b0;
        end
    end

    assign busy = busy_q;

    nand_ecc_syndrome #(.PAIRS(PAIRS), .SEC_W(SEC_W)) u_syn (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_idx   (load_idx),
        .load_last  (load_last),
        .stored_raw (st_sec[load_idx]),
        .calc_raw   (ca_sec[load_idx]),
        .s1_valid   (s1_valid),
        .s1_idx     (s1_idx),
        .s1_last    (s1_last),
        .s1_syn_odd (s1_syn_odd),
        .s1_pop     (s1_pop),
        .s1_erased  (s1_erased),
        .s1_same    (s1_same)
    );

    nand_ecc_classify #(
        .PAIRS(PAIRS), .SEC_W(SEC_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
    ) u_cls (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_idx      (s1_idx),
        .s1_last     (s1_last),
        .s1_syn_odd  (s1_syn_odd),
        .s1_pop      (s1_pop),
        .s1_erased   (s1_erased),
        .s1_same     (s1_same),
        .fail_now    (fail_now),
        .stat_valid  (stat_valid),
        .stat_code   (stat_code),
        .stat_sector (stat_sector),
        .stat_last   (stat_last),
        .fix_byte    (fix_byte),
        .fix_bit     (fix_bit),
        .fix_we      (fix_we),
        .fix_addr    (fix_addr),
        .fix_mask    (fix_mask)
    );
endmodule

// File: rtl/nand_ecc_corrector_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the ECC corrector, bound to every instance.
module nand_ecc_corrector_chk #(
    parameter int SEC_W  = 2,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              stat_valid,
    input logic [1:0]        stat_code,
    input logic [SEC_W-1:0]  stat_sector,
    input logic              stat_last,
    input logic [BYTE_W-1:0] fix_byte,
    input logic [2:0]        fix_bit,
    input logic              fix_we,
    input logic [ADDR_W-1:0] fix_addr,
    input logic [7:0]        fix_mask
);
    // R8: accepted request yields sector 0 status two edges later
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |-> ##2 (stat_valid && stat_sector == '0));

    // R3: non-corrected status carries no repair
    p_quiet_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code != 2'b01 |-> !fix_we && fix_mask == 8'd0 &&
        fix_byte == '0 && fix_bit == 3'd0);

    // R5: repair strobe only with a corrected status, single-bit mask
    p_fix_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |-> stat_valid && stat_code == 2'b01 && $countones(fix_mask) == 1 &&
        fix_addr[BYTE_W-1:0] == fix_byte);

    // R6: illegal status code never appears
    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> stat_code != 2'b11);

    // R10: uncorrectable sector ends the request
    p_fail_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code == 2'b10 |-> stat_last);

    // R10: busy is low with the final status
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_last |-> !busy);

    // R9: busy stays high while more statuses follow
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && !stat_last |-> busy);

    // R9: next sector follows on the very next cycle
    p_next_sector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && !stat_last |=> stat_valid &&
        (stat_sector - $past(stat_sector)) == SEC_W'(1));
endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk #(
    .SEC_W(SEC_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .stat_valid  (stat_valid),
    .stat_code   (stat_code),
    .stat_sector (stat_sector),
    .stat_last   (stat_last),
    .fix_byte    (fix_byte),
    .fix_bit     (fix_bit),
    .fix_we      (fix_we),
    .fix_addr    (fix_addr),
    .fix_mask    (fix_mask)
);

// File: tb/nand_ecc_corrector_test.sv
`timescale 1ns/1ps
module nand_ecc_corrector_test;
    localparam int NSEC = 4;
    localparam int CW   = 24;
    localparam int SB   = 512;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, page_mode = 1'b0;
    logic [NSEC*CW-1:0] st_all = '0, ca_all = '0;
    logic busy, stat_valid, stat_last, fix_we;
    logic [1:0] stat_code, stat_sector;
    logic [8:0] fix_byte;
    logic [2:0] fix_bit;
    logic [10:0] fix_addr;
    logic [7:0] fix_mask;

    nand_ecc_corrector uut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
        .stored_code(st_all), .calc_code(ca_all), .busy(busy),
        .stat_valid(stat_valid), .stat_code(stat_code), .stat_sector(stat_sector),
        .stat_last(stat_last), .fix_byte(fix_byte), .fix_bit(fix_bit),
        .fix_we(fix_we), .fix_addr(fix_addr), .fix_mask(fix_mask)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit finished = 0, cmp_on = 0;

    typedef struct {
        int at; int sec; int code; int bo; int bi; bit last; string tag;
    } exp_t;
    exp_t q[$];
    int b_from = 0, b_till = -1;

    // raw bit position of the even / odd parity of span 2^k (R2)
    function automatic int pe(int k); return (k < 8) ? k : 16 + k - 8; endfunction
    function automatic int po(int k); return (k < 8) ? 8 + k : 20 + k - 8; endfunction

    function automatic void ref_class(input logic [23:0] s, input logic [23:0] c,
                                      output int code, output int bo, output int bi);
        int pop = 0, loc = 0;
        for (int k = 0; k < 12; k++) begin
            if (s[pe(k)] != c[pe(k)]) pop++;
            if (s[po(k)] != c[po(k)]) begin pop++; loc += (1 << k); end
        end
        bo = 0; bi = 0;
        if (s == c) code = 0;
        else if (pop == 12) begin code = 1; bo = loc >> 3; bi = loc & 7; end
        else if (s == 24'hFFFFFF && c == 24'h0) code = 0;
        else code = 2;
    endfunction

    // stored code as seen after one data bit flips
    function automatic logic [23:0] inject(input logic [23:0] c, input int bo, input int bi);
        logic [23:0] r = c;
        int a = bo * 8 + bi;
        for (int k = 0; k < 12; k++) begin
            if ((a >> k) & 1) r[po(k)] = ~r[po(k)];
            else              r[pe(k)] = ~r[pe(k)];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic bit model_busy();
        return (cyc >= b_from) && (cyc <= b_till);
    endfunction

    task automatic set_sec(input int i, input logic [23:0] s, input logic [23:0] c);
        st_all[i*CW +: CW] = s;
        ca_all[i*CW +: CW] = c;
    endtask

    // Drive one start pulse; the model decides acceptance from its own busy view
    task automatic issue(input bit mode, input string tag);
        start = 1'b1;
        page_mode = mode;
        if (!model_busy()) begin
            int a = cyc + 1;
            int n = 0;
            int cnt = mode ? NSEC : 1;
            for (int i = 0; i < cnt; i++) begin
                int code, bo, bi;
                exp_t e;
                ref_class(st_all[i*CW +: CW], ca_all[i*CW +: CW], code, bo, bi);
                e.at = a + 1 + i; e.sec = i; e.code = code; e.bo = bo; e.bi = bi;
                e.last = (code == 2) || (i == cnt - 1); e.tag = tag;
                q.push_back(e);
                n++;
                if (e.last) break;
            end
            b_from = a;
            b_till = a + n - 1;
        end
        step();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || model_busy()) step();
    endtask

    // Reference comparison on every clock, away from the active edge
    bit ev, eb;
    exp_t ce;
    always @(negedge clk) begin
        if (cmp_on) begin
            ev = (q.size() > 0) && (q[0].at == cyc);
            eb = model_busy();
            chk(busy === eb, "R8/R11", "busy", busy, eb);
            chk(stat_valid === ev, "R8", "stat_valid", stat_valid, ev);
            if (ev) begin
                ce = q.pop_front();
                chk(stat_code === 2'(ce.code), ce.tag, "stat_code", stat_code, ce.code);
                chk(stat_sector === 2'(ce.sec), "R9", "stat_sector", stat_sector, ce.sec);
                chk(stat_last === ce.last, "R10", "stat_last", stat_last, ce.last);
                chk(fix_byte === 9'(ce.bo), "R4", "fix_byte", fix_byte, ce.bo);
                chk(fix_bit === 3'(ce.bi), "R4", "fix_bit", fix_bit, ce.bi);
                chk(fix_we === (ce.code == 1), "R5", "fix_we", fix_we, ce.code == 1);
                chk(fix_addr === 11'((ce.code == 1) ? ce.sec * SB + ce.bo : 0), "R5",
                    "fix_addr", fix_addr, (ce.code == 1) ? ce.sec * SB + ce.bo : 0);
                chk(fix_mask === 8'((ce.code == 1) ? (1 << ce.bi) : 0), "R5",
                    "fix_mask", fix_mask, (ce.code == 1) ? (1 << ce.bi) : 0);
            end else begin
                chk(fix_we === 1'b0, "R5", "fix_we idle", fix_we, 0);
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        logic [23:0] c;
        repeat (3) step();
        // R1: outputs quiet under reset
        chk(busy === 1'b0, "R1", "busy", busy, 0);
        chk(stat_valid === 1'b0, "R1", "stat_valid", stat_valid, 0);
        chk(stat_code === 2'b00, "R1", "stat_code", stat_code, 0);
        chk(fix_we === 1'b0 && fix_mask === 8'd0, "R1", "fix_we/mask", fix_mask, 0);
        chk(fix_addr === 11'd0 && fix_byte === 9'd0, "R1", "fix_addr", fix_addr, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        step();

        // R3/R12: equal codes, other slices hold failing garbage
        set_sec(0, 24'h3C5A96, 24'h3C5A96);
        set_sec(1, 24'h000001, 24'h000000);
        set_sec(2, 24'h123456, 24'h654321);
        set_sec(3, 24'h0000FF, 24'h000000);
        issue(0, "R3/R12"); wait_idle();

        // R2/R4: single flipped bits at interior and extreme positions
        c = 24'h5A1C33; set_sec(0, inject(c, 9'h1A5, 6), c); issue(0, "R2/R4"); wait_idle();
        c = 24'h000000; set_sec(0, inject(c, 0, 0), c);      issue(0, "R2/R4"); wait_idle();
        c = 24'hA0F00F; set_sec(0, inject(c, 511, 7), c);    issue(0, "R2/R4"); wait_idle();

        // R6: weight 1 and weight 11
        c = 24'h71B2C4; set_sec(0, c ^ 24'h000020, c); issue(0, "R6"); wait_idle();
        c = 24'h0E0E0E; set_sec(0, inject(c, 77, 3) ^ (24'h1 << pe(0)) ^ (24'h1 << po(0)), c);
        set_sec(0, inject(c, 77, 3), c);
        st_all[pe(5)] = ca_all[pe(5)]; st_all[po(5)] = ca_all[po(5)];
        issue(0, "R6"); wait_idle();

        // R7: erased pair, then all-ones stored against a live code
        set_sec(0, 24'hFFFFFF, 24'h000000); issue(0, "R7"); wait_idle();
        set_sec(0, 24'hFFFFFF, 24'h0C0030); issue(0, "R6"); wait_idle();

        // R9: full page, clean / fixed / fixed / clean
        set_sec(0, 24'h111111, 24'h111111);
        c = 24'h2468AC; set_sec(1, inject(c, 300, 2), c);
        c = 24'h13579B; set_sec(2, inject(c, 5, 5), c);
        set_sec(3, 24'hFFFFFF, 24'h000000);
        issue(1, "R9"); wait_idle();

        // R10: sector 1 uncorrectable ends the page; R11 start while busy ignored
        set_sec(1, 24'h000003, 24'h000000);
        issue(1, "R10");
        issue(0, "R11");
        wait_idle();

        // R11: back-to-back request in the final-status cycle
        set_sec(1, 24'h777777, 24'h777777);
        issue(1, "R9");
        while (cyc != b_till + 1) step();
        c = 24'h00FF00; set_sec(0, inject(c, 128, 1), c);
        issue(0, "R11");
        wait_idle();

        // Mixed random traffic
        for (int it = 0; it < 80; it++) begin
            for (int i = 0; i < NSEC; i++) begin
                logic [23:0] a = 24'($urandom);
                logic [23:0] b = 24'($urandom);
                case ($urandom % 5)
                    0: set_sec(i, a, a);
                    1: set_sec(i, inject(a, $urandom % SB, $urandom % 8), a);
                    2: set_sec(i, b, a);
                    3: set_sec(i, 24'hFFFFFF, 24'h0);
                    default: set_sec(i, a ^ (24'h1 << ($urandom % 24)), a);
                endcase
            end
            issue(1'($urandom % 2), "R3/R4/R6/R7");
            if ($urandom % 3 == 0) issue(0, "R11");
            wait_idle();
        end

        repeat (4) step();
        summary();
    end
endmodule